// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial (I2C, standard mode) slave that holds a small bank of 8-bit configuration registers for a clock generator. A host programs the bank with one block write and can verify it with one block read. The slave keeps no register pointer. Every write fills the bank from register 0 upward. Every read returns a byte count first and then the whole bank in ascending order.

The bus lines enter as plain inputs. The slave pulls the data line low through a single output-enable, and an external pull-up supplies the high level. Both lines are resynchronised to the system clock, and all protocol decoding runs on that clock. The register contents leave the block as one flat vector, with register k in bits [8k+7:8k], and feed the clock-generation logic directly.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the bank holds register 0 = 0x00, register 1 = 0x3F, register 2 = 0xFF, register 3 = 0x3F, register 4 = 0xF5 and register 5 = 0xFF, and the slave does not pull the data line.
- R2: An address byte of 0xD2 (7-bit address 0x69, direction bit 0) is acknowledged by pulling the data line low during the ninth clock.
- R3: An address byte of 0xD3 is acknowledged. Any other address byte is not acknowledged, and the bytes that follow it are neither acknowledged nor stored until the next start.
- R4: In a write, the two bytes after the address (a command code and a byte count) are acknowledged, and their values change no register.
- R5: Write data bytes, sent MSB first, are stored into registers 0, 1, 2, ... in the order they arrive, and each one is acknowledged.
- R6: A stop after any complete byte ends the write. Registers written before the stop hold their new values, and all later registers keep their old values.
- R7: Data bytes beyond register 5 are acknowledged and discarded.
- R8: In a read, the slave sends the byte count 0x06 and then registers 0 to 5, each MSB first, and changes the data line only while the clock line is low.
- R9: A NACK from the master after any read byte ends the read. The slave then leaves the data line released.
- R10: A start or repeated start (data falling while the clock is high) begins a new address phase from any state. A stop (data rising while the clock is high) returns the slave to idle with the data line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| cfg_o | output | 48 | Register bank; register k occupies bits [8k+7:8k] |

## Verification
Two events can fall on the same protocol boundary: the commit of a data byte into the bank and a stop or repeated start. Both happen in the bus-clock-low window that follows the eighth bit and its acknowledge. The bench ends writes after a random number of data bytes, including zero and more than six. It also cuts a write short with a repeated start followed by a read. Each case is judged by comparing the register port and the read-back bytes against a bench model that updates only the registers whose bytes were fully sent.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

   // protocol phase of the byte engine
   typedef enum logic [2:0] {
      BUS_IDLE,   // waiting for a start
      BUS_RECV,   // shifting in a byte from the master
      BUS_RACK,   // slave drives acknowledge
      BUS_SEND,   // shifting out a byte to the master
      BUS_SACK    // master drives acknowledge
   } bus_st_e;

   localparam int BYTE_W    = 8;
   // address, command code and byte count precede write data
   localparam int HDR_BYTES = 3;

endpackage

// File: rtl/cfg_i2c_sampler.sv
module cfg_i2c_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   localparam int PIPE_W = 2 * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_i2c_sampler: STAGES must be at least 2");
   end

   logic [PIPE_W-1:0] pipe_q;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         pipe_q <= {pipe_q[PIPE_W-3:0], scl_i, sda_i};
         scl_p  <= pipe_q[PIPE_W-1];
         sda_p  <= pipe_q[PIPE_W-2];
      end
   end

   assign scl_s     = pipe_q[PIPE_W-1];
   assign sda_s     = pipe_q[PIPE_W-2];
   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_evt =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_evt  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile #(
   parameter int                    NUM_REGS = 6,
   parameter logic [NUM_REGS*8-1:0] RST_VALS = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_REGS-1:0]   wr_en,
   input  logic [7:0]            wr_data,
   output logic [NUM_REGS*8-1:0] regs_o
);

   genvar g;
   generate
      for (g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs_o[g*8 +: 8] <= RST_VALS[g*8 +: 8];
            else if (wr_en[g])
               regs_o[g*8 +: 8] <= wr_data;
         end

         // R6
         reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[g] |=> $stable(regs_o[g*8 +: 8]))
            else $error("register %0d changed without a write", g);
      end
   endgenerate

   // R5
   wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en))
      else $error("more than one register written at once");

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
   import cfg_i2c_pkg::*;
#(
   parameter int         NUM_REGS = 6,
   parameter logic [6:0] DEV_ADDR = 7'h69
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_s,
   input  logic                  sda_s,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  start_evt,
   input  logic                  stop_evt,
   input  logic [NUM_REGS*8-1:0] rd_data,
   output logic                  sda_oe_o,
   output logic [NUM_REGS-1:0]   wr_en,
   output logic [7:0]            wr_data
);

   localparam int IDX_MAX = HDR_BYTES + NUM_REGS;
   localparam int IDX_W   = $clog2(IDX_MAX + 1);
   localparam int TXI_MAX = NUM_REGS + 1;
   localparam int TXI_W   = $clog2(TXI_MAX + 1);
   localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

   bus_st_e            state;
   logic [3:0]         bit_cnt;
   logic [IDX_W-1:0]   byte_idx;
   logic [TXI_W-1:0]   tx_idx;
   logic [7:0]         rx_sh, tx_sh;
   logic               is_read, m_nack;
   logic [NUM_REGS-1:0] data_hit;
   logic [7:0]         next_tx;

   // which register the current receive byte belongs to
   always_comb begin
      for (int i = 0; i < NUM_REGS; i++)
         data_hit[i] = (byte_idx == IDX_W'(HDR_BYTES + i));
   end

   // byte to send after the current one
   always_comb begin
      next_tx = 8'hFF;
      if (tx_idx == '0)
         next_tx = COUNT_BYTE;
      for (int i = 0; i < NUM_REGS; i++)
         if (tx_idx == TXI_W'(i + 1))
            next_tx = rd_data[i*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= BUS_IDLE;
         bit_cnt  <= '0;
         byte_idx <= '0;
         tx_idx   <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         is_read  <= 1'b0;
         m_nack   <= 1'b0;
         sda_oe_o <= 1'b0;
         wr_en    <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= '0;
         if (start_evt) begin
            state    <= BUS_RECV;
            bit_cnt  <= '0;
            byte_idx <= '0;
            is_read  <= 1'b0;
            sda_oe_o <= 1'b0;
         end else if (stop_evt) begin
            state    <= BUS_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (state)
               BUS_IDLE: sda_oe_o <= 1'b0;
               BUS_RECV: begin
                  if (scl_rise && bit_cnt != 4'd8) begin
                     rx_sh   <= {rx_sh[6:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (byte_idx == '0) begin
                        if (rx_sh[7:1] == DEV_ADDR) begin
                           is_read  <= rx_sh[0];
                           sda_oe_o <= 1'b1;
                           state    <= BUS_RACK;
                        end else begin
                           state <= BUS_IDLE;
                        end
                     end else begin
                        sda_oe_o <= 1'b1;
                        state    <= BUS_RACK;
                        wr_en    <= data_hit;
                        wr_data  <= rx_sh;
                     end
                  end
               end
               BUS_RACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (byte_idx != IDX_W'(IDX_MAX))
                        byte_idx <= byte_idx + 1'b1;
                     if (is_read) begin
                        state    <= BUS_SEND;
                        tx_sh    <= COUNT_BYTE;
                        tx_idx   <= TXI_W'(1);
                        sda_oe_o <= ~COUNT_BYTE[7];
                     end else begin
                        state    <= BUS_RECV;
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               BUS_SEND: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd7) begin
                        state    <= BUS_SACK;
                        sda_oe_o <= 1'b0;
                     end else begin
                        tx_sh    <= {tx_sh[6:0], 1'b0};
                        sda_oe_o <= ~tx_sh[6];
                        bit_cnt  <= bit_cnt + 4'd1;
                     end
                  end
               end
               BUS_SACK: begin
                  if (scl_rise)
                     m_nack <= sda_s;
                  else if (scl_fall) begin
                     if (!m_nack) begin
                        state    <= BUS_SEND;
                        tx_sh    <= next_tx;
                        sda_oe_o <= ~next_tx[7];
                        bit_cnt  <= '0;
                        if (tx_idx != TXI_W'(TXI_MAX))
                           tx_idx <= tx_idx + 1'b1;
                     end else begin
                        state    <= BUS_IDLE;
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               default: state <= BUS_IDLE;
            endcase
         end
      end
   end

   // R8
   sda_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !$past(scl_s))
      else $error("data line pulled while clock high");

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe_o)
      else $error("data line still pulled after stop");

   // R9
   nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BUS_SACK && scl_fall && m_nack && !start_evt && !stop_evt) |=> !sda_oe_o)
      else $error("data line pulled after master nack");

   // R5
   bit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= 4'd8)
      else $error("bit counter out of range");

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
   parameter int                    NUM_REGS    = 6,
   parameter logic [6:0]            DEV_ADDR    = 7'h69,
   parameter int                    SYNC_STAGES = 2,
   parameter logic [NUM_REGS*8-1:0] RST_VALS    = 48'hFF_F5_3F_FF_3F_00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   output logic [NUM_REGS*8-1:0] cfg_o
);

   if (NUM_REGS < 1 || NUM_REGS > 250) begin : g_bad_regs
      $error("cfg_i2c_slave: NUM_REGS must be 1..250");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic [NUM_REGS-1:0] wr_en;
   logic [7:0]          wr_data;

   cfg_i2c_sampler #(.STAGES(SYNC_STAGES)) sampler_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   cfg_i2c_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) engine_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .rd_data   (cfg_o),
      .sda_oe_o  (sda_oe_o),
      .wr_en     (wr_en),
      .wr_data   (wr_data)
   );

   cfg_i2c_regfile #(.NUM_REGS(NUM_REGS), .RST_VALS(RST_VALS)) regfile_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .regs_o  (cfg_o)
   );

endmodule

// File: tb/cfg_i2c_slave_tb_top.sv
module cfg_i2c_slave_tb_top;

   localparam int NREG = 6;
   localparam int Q    = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe;
   logic sda_line;
   logic [NREG*8-1:0] cfg;

   int n_chk = 0;
   int n_bad = 0;
   int hi_violations = 0;
   bit finished = 0;
   logic [7:0] model [NREG];
   logic [7:0] wbuf [12];

   assign sda_line = ~(m_low | sda_oe);

   always #5 clk = ~clk;

   cfg_i2c_slave dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (m_scl),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe),
      .cfg_o    (cfg)
   );

   // R8 monitor: slave must not move the data line while the clock is high
   logic prev_oe = 1'b0;
   logic prev_scl = 1'b1;
   always @(negedge clk) begin
      if (rst_n && prev_scl && m_scl && sda_oe != prev_oe)
         hi_violations++;
      prev_oe  <= sda_oe;
      prev_scl <= m_scl;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic end_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_low = 1'b1; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; wq();
      m_scl = 1'b1; wq();
      m_low = 1'b0; wq(); wq();
   endtask

   task automatic tx_bit(input logic b);
      m_low = ~b; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic rx_bit(output logic b);
      m_low = 1'b0; wq();
      m_scl = 1'b1; wq();
      b = sda_line; wq();
      m_scl = 1'b0; wq();
   endtask

   // returns 0 when the slave acknowledged
   task automatic tx_byte(input logic [7:0] d, output logic ack_n);
      for (int i = 7; i >= 0; i--) tx_bit(d[i]);
      rx_bit(ack_n);
   endtask

   task automatic rx_byte(input logic give_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rx_bit(b);
         d[i] = b;
      end
      tx_bit(~give_ack);
      m_low = 1'b0;
   endtask

   function automatic logic [NREG*8-1:0] model_vec();
      logic [NREG*8-1:0] v;
      for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
      return v;
   endfunction

   // write n data bytes from wbuf; optionally finish with stop
   task automatic do_write(input int n, input bit with_stop);
      logic a;
      bus_start();
      tx_byte(8'hD2, a);
      check("R2 write address ack", a, 0);
      tx_byte(8'($urandom()), a);
      check("R4 command code ack", a, 0);
      tx_byte(8'($urandom()), a);
      check("R4 byte count ack", a, 0);
      for (int i = 0; i < n; i++) begin
         tx_byte(wbuf[i], a);
         check(i < NREG ? "R5 data ack" : "R7 extra byte ack", a, 0);
         if (i < NREG) model[i] = wbuf[i];
      end
      if (with_stop) begin
         bus_stop();
         check("R6 register port after write", cfg, model_vec());
         check("R10 released after stop", sda_oe, 0);
      end
   endtask

   task automatic do_read(input int n);
      logic a;
      logic [7:0] d;
      bus_start();
      tx_byte(8'hD3, a);
      check("R3 read address ack", a, 0);
      rx_byte(n > 0, d);
      check("R8 byte count", d, 8'h06);
      for (int i = 0; i < n; i++) begin
         rx_byte(i < n - 1, d);
         check("R8 read-back byte", d, model[i]);
      end
      check("R9 released after nack", sda_oe, 0);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      end_run();
   end

   initial begin
      logic a;
      void'($urandom(32'd20240611));
      model[0] = 8'h00; model[1] = 8'h3F; model[2] = 8'hFF;
      model[3] = 8'h3F; model[4] = 8'hF5; model[5] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      check("R1 reset values", cfg, 48'hFF_F5_3F_FF_3F_00);
      check("R1 line released", sda_oe, 0);
      do_read(NREG);

      // R5 full write
      for (int i = 0; i < 12; i++) wbuf[i] = 8'(8'h11 * (i + 1));
      do_write(NREG, 1);
      do_read(NREG);

      // R7 more bytes than registers
      for (int i = 0; i < 12; i++) wbuf[i] = 8'(8'hA0 + i);
      do_write(9, 1);
      do_read(NREG);

      // R6 stop after two data bytes, and after none
      wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
      do_write(2, 1);
      do_write(0, 1);
      do_read(NREG);

      // R3 wrong addresses: no ack, following bytes ignored
      bus_start();
      tx_byte(8'hA4, a);
      check("R3 foreign address nack", a, 1);
      for (int i = 0; i < 4; i++) begin
         tx_byte(8'h00, a);
         check("R3 bytes after foreign address nack", a, 1);
      end
      bus_stop();
      check("R3 registers untouched", cfg, model_vec());
      bus_start();
      tx_byte(8'hD0, a);
      check("R3 neighbour address nack", a, 1);
      bus_stop();

      // R10 repeated start cuts a write short, then read
      wbuf[0] = 8'h69; wbuf[1] = 8'h96; wbuf[2] = 8'h3C;
      do_write(3, 0);
      do_read(NREG);
      check("R10 port after repeated start", cfg, model_vec());

      // R9 early nack after third register
      do_read(3);
      do_read(0);

      // random block writes of random length
      for (int it = 0; it < 8; it++) begin
         int n;
         n = int'($urandom_range(0, 8));
         for (int i = 0; i < 12; i++) wbuf[i] = 8'($urandom());
         do_write(n, 1);
         do_read(int'($urandom_range(1, NREG)));
      end

      check("R8 no data change while clock high", hi_violations, 0);
      end_run();
   end

endmodule